// File: doc/BRIEF.md
# Instruction Length and Jump-Target Checker

This block belongs to the fetch/decode boundary of a RISC-V style core. Each accepted request carries a fetched 32-bit instruction word, the program counter of that word, and a flag that says whether 16-bit compressed encodings are allowed. From these the block works out two things. The first is the length of the instruction, which gives the sequential successor address. The second applies when the word is a 32-bit jump-and-link (JAL). For a JAL the block computes the jump target, decides whether that target is legal, and forms the return-address value together with a write enable for the destination register.

Illegal compressed encodings and misaligned jump targets are turned into an exception strobe with a cause code and the faulting PC. Results are registered and appear one clock after the request is accepted. A full decoder, the register file and memory access lie outside the block.

Top module: `ilen_jtgt_chk`

## Requirements
- R1: `out_short` is 1 when bits [1:0] of the instruction are anything other than 2'b11, and 0 when both are 1.
- R2: `out_seq_pc` equals the request PC plus 2 for a short instruction and plus 4 for a 32-bit one, modulo 2^XLEN.
- R3: A short instruction accepted while `in_cext_en` is 0 raises an exception with cause 2 (illegal instruction) and produces neither a jump nor a link write.
- R4: A 32-bit word with opcode bits [6:0] = 7'b1101111 is a JAL. Its target is PC plus the sign-extended 21-bit offset {insn[31], insn[19:12], insn[20], insn[30:21], 1'b0}. Any other word never asserts `out_jump`.
- R5: With `in_cext_en` = 0, a JAL whose target has either of bits [1:0] set raises an exception with cause 0 (misaligned target), and both `out_jump` and `out_link_we` stay 0.
- R6: With `in_cext_en` = 1, a JAL jumps whatever the low bits of its target, and no misaligned exception is raised.
- R7: For a taken JAL, `out_link_val` equals the successor PC and `out_link_rd` equals insn[11:7]. `out_link_we` is 1 only when that field is nonzero.
- R8: When an exception is raised, `fault_pc` holds the PC of the faulting request. It keeps that value until the next exception.
- R9: A request is accepted when `in_valid` and `in_ready` are both 1. `out_valid`, and `exc_valid` when a fault occurs, are 1 for exactly the one cycle after the accept and 0 otherwise.
- R10: While `rst` is 1, at the next clock edge every output is cleared to 0, including `in_ready`. `in_ready` becomes 1 on the first edge after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_insn | input | 32 | Fetched instruction word |
| in_pc | input | XLEN | Address of the instruction |
| in_cext_en | input | 1 | Compressed encodings allowed |
| out_valid | output | 1 | Result strobe, one cycle |
| out_short | output | 1 | Instruction is 16 bits |
| out_seq_pc | output | XLEN | Sequential successor PC |
| out_jump | output | 1 | JAL taken |
| out_target | output | XLEN | JAL target address |
| out_link_we | output | 1 | Write return address |
| out_link_rd | output | 5 | Destination register index |
| out_link_val | output | XLEN | Return address value |
| exc_valid | output | 1 | Exception strobe, one cycle |
| exc_cause | output | 4 | 2 = illegal instruction, 0 = misaligned target |
| fault_pc | output | XLEN | PC of the last faulting request |

## Verification
The block keeps no state beyond its output registers and the last fault address. A wrong length decision, offset extraction or alignment decision therefore shows on the ports on the very next cycle after the request is accepted. It appears as a wrong successor PC, a wrong target, a jump or link write that should not be there, or a wrong cause code. A stale or corrupted `fault_pc` only becomes visible at the next exception, so the sweep raises faults at many PCs in succession. The sweep covers both settings of the compressed flag, PCs on 2-byte and 4-byte boundaries including wraparound, JAL offsets from the extremes of the 21-bit range, and destination register zero.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
  localparam int CAUSE_W = 4;
  localparam int RIDX_W  = 5;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_MISALIGNED = 4'd0,
    CAUSE_ILLEGAL    = 4'd2
  } cause_e;

  localparam logic [6:0] OPC_JAL = 7'b1101111;
endpackage

// File: rtl/ilc_length.sv
module ilc_length #(
  parameter int XLEN = 32
) (
  input  logic [1:0]      low_bits,
  input  logic [XLEN-1:0] pc,
  input  logic            cext_en,
  output logic            is_short,
  output logic            illegal,
  output logic [XLEN-1:0] seq_pc
);
  localparam logic [XLEN-1:0] STEP_SHORT = XLEN'(2);
  localparam logic [XLEN-1:0] STEP_LONG  = XLEN'(4);

  always_comb begin
    is_short = (low_bits != 2'b11);
    illegal  = is_short && !cext_en;
    seq_pc   = pc + (is_short ? STEP_SHORT : STEP_LONG);
  end
endmodule

// File: rtl/ilc_jal_unit.sv
module ilc_jal_unit
  import ilc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]       insn,
  input  logic [XLEN-1:0]   pc,
  input  logic              cext_en,
  input  logic              is_short,
  output logic              is_jal,
  output logic [XLEN-1:0]   target,
  output logic              misaligned,
  output logic [RIDX_W-1:0] rd
);
  localparam int OFS_W = 21;

  logic [OFS_W-1:0] ofs;
  logic [XLEN-1:0]  ofs_ext;

  always_comb begin
    ofs        = {insn[31], insn[19:12], insn[20], insn[30:21], 1'b0};
    ofs_ext    = {{(XLEN-OFS_W){ofs[OFS_W-1]}}, ofs};
    is_jal     = !is_short && (insn[6:0] == OPC_JAL);
    target     = pc + ofs_ext;
    misaligned = is_jal && !cext_en && (target[1:0] != 2'b00);
    rd         = insn[11:7];
  end
endmodule

// File: rtl/ilen_jtgt_chk.sv
module ilen_jtgt_chk
  import ilc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [31:0]         in_insn,
  input  logic [XLEN-1:0]     in_pc,
  input  logic                in_cext_en,
  output logic                out_valid,
  output logic                out_short,
  output logic [XLEN-1:0]     out_seq_pc,
  output logic                out_jump,
  output logic [XLEN-1:0]     out_target,
  output logic                out_link_we,
  output logic [RIDX_W-1:0]   out_link_rd,
  output logic [XLEN-1:0]     out_link_val,
  output logic                exc_valid,
  output logic [CAUSE_W-1:0]  exc_cause,
  output logic [XLEN-1:0]     fault_pc
);
  logic              accept;
  logic              is_short, illegal, is_jal, misaligned;
  logic [XLEN-1:0]   seq_pc, target;
  logic [RIDX_W-1:0] rd;
  logic              fault, take;

  ilc_length #(.XLEN(XLEN)) u_len (
    .low_bits (in_insn[1:0]),
    .pc       (in_pc),
    .cext_en  (in_cext_en),
    .is_short (is_short),
    .illegal  (illegal),
    .seq_pc   (seq_pc)
  );

  ilc_jal_unit #(.XLEN(XLEN)) u_jal (
    .insn       (in_insn),
    .pc         (in_pc),
    .cext_en    (in_cext_en),
    .is_short   (is_short),
    .is_jal     (is_jal),
    .target     (target),
    .misaligned (misaligned),
    .rd         (rd)
  );

  always_comb begin
    accept = in_valid && in_ready;
    fault  = illegal || misaligned;
    take   = is_jal && !misaligned;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready     <= 1'b0;
      out_valid    <= 1'b0;
      out_short    <= 1'b0;
      out_seq_pc   <= '0;
      out_jump     <= 1'b0;
      out_target   <= '0;
      out_link_we  <= 1'b0;
      out_link_rd  <= '0;
      out_link_val <= '0;
      exc_valid    <= 1'b0;
      exc_cause    <= '0;
      fault_pc     <= '0;
    end else begin
      in_ready  <= 1'b1;
      out_valid <= accept;
      exc_valid <= accept && fault;
      if (accept) begin
        out_short    <= is_short;
        out_seq_pc   <= seq_pc;
        out_jump     <= take;
        out_target   <= target;
        out_link_we  <= take && (rd != '0);
        out_link_rd  <= rd;
        out_link_val <= seq_pc;
        if (fault) begin
          exc_cause <= illegal ? CAUSE_ILLEGAL : CAUSE_MISALIGNED;
          fault_pc  <= in_pc;
        end
      end
    end
  end
endmodule

// File: rtl/ilc_checker.sv
module ilc_checker
  import ilc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic [31:0]         in_insn,
  input logic [XLEN-1:0]     in_pc,
  input logic                in_cext_en,
  input logic                out_valid,
  input logic                out_short,
  input logic [XLEN-1:0]     out_seq_pc,
  input logic                out_jump,
  input logic [XLEN-1:0]     out_target,
  input logic                out_link_we,
  input logic [RIDX_W-1:0]   out_link_rd,
  input logic [XLEN-1:0]     out_link_val,
  input logic                exc_valid,
  input logic [CAUSE_W-1:0]  exc_cause,
  input logic [XLEN-1:0]     fault_pc
);
  // R9
  result_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready));

  // R9
  exc_with_result_chk: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> out_valid);

  // R5
  no_jump_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (!out_jump && !out_link_we));

  // R7
  no_link_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_link_we |-> (out_link_rd != '0 && out_jump));

  // R6
  aligned_unless_cext_chk: assert property (@(posedge clk) disable iff (rst)
    out_jump |-> ((out_target[1:0] == 2'b00) || $past(in_cext_en)));

  // R8
  fault_pc_capture_chk: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (fault_pc == $past(in_pc)));

  // R3
  short_illegal_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && out_short) |-> (exc_cause == CAUSE_ILLEGAL));
endmodule

bind ilen_jtgt_chk ilc_checker #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_ilen_jtgt_chk.sv
module sim_ilen_jtgt_chk;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_insn;
  logic [31:0] in_pc;
  logic        in_cext_en;
  logic        out_valid, out_short, out_jump, out_link_we, exc_valid;
  logic [31:0] out_seq_pc, out_target, out_link_val, fault_pc;
  logic [4:0]  out_link_rd;
  logic [3:0]  exc_cause;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  ilen_jtgt_chk #(.XLEN(32)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_pc(in_pc), .in_cext_en(in_cext_en),
    .out_valid(out_valid), .out_short(out_short), .out_seq_pc(out_seq_pc),
    .out_jump(out_jump), .out_target(out_target), .out_link_we(out_link_we),
    .out_link_rd(out_link_rd), .out_link_val(out_link_val),
    .exc_valid(exc_valid), .exc_cause(exc_cause), .fault_pc(fault_pc)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] last_fault;

  // imm is the signed JAL offset the bench encoded (0 for non-JAL words)
  task automatic run_one(input logic [31:0] insn, input logic [31:0] pc,
                         input bit cext, input logic [31:0] imm);
    bit          sh, ill, jal, mis, jmp, lwe, exc;
    logic [31:0] seq, tgt;
    logic [4:0]  rd;
    sh  = (insn[1:0] != 2'b11);
    seq = pc + (sh ? 32'd2 : 32'd4);
    ill = sh && !cext;
    jal = !sh && (insn[6:0] == 7'h6f);
    tgt = pc + imm;
    mis = jal && !cext && (tgt[1:0] != 2'b00);
    jmp = jal && !mis;
    rd  = insn[11:7];
    lwe = jmp && (rd != 5'd0);
    exc = ill || mis;
    @(negedge clk);
    in_valid = 1'b1; in_insn = insn; in_pc = pc; in_cext_en = cext;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R9 out_valid", 32'(out_valid), 32'd1);
    chk(out_short == sh, "R1 length", 32'(out_short), 32'(sh));
    chk(out_seq_pc == seq, "R2 seq_pc", out_seq_pc, seq);
    chk(exc_valid == exc, "R3/R5 exc_valid", 32'(exc_valid), 32'(exc));
    if (ill)
      chk(exc_cause == 4'd2, "R3 cause", 32'(exc_cause), 32'd2);
    if (mis)
      chk(exc_cause == 4'd0, "R5 cause", 32'(exc_cause), 32'd0);
    if (exc) last_fault = pc;
    chk(fault_pc == last_fault, "R8 fault_pc", fault_pc, last_fault);
    chk(out_jump == jmp, jal && cext ? "R6 jump" : "R4 jump",
        32'(out_jump), 32'(jmp));
    if (jal)
      chk(out_target == tgt, "R4 target", out_target, tgt);
    chk(out_link_we == lwe, "R7 link_we", 32'(out_link_we), 32'(lwe));
    if (jmp) begin
      chk(out_link_val == seq, "R7 link_val", out_link_val, seq);
      chk(out_link_rd == rd, "R7 link_rd", 32'(out_link_rd), 32'(rd));
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 strobe width", 32'(out_valid), 32'd0);
    chk(exc_valid == 1'b0, "R9 exc strobe width", 32'(exc_valid), 32'd0);
  endtask

  function automatic logic [31:0] enc_jal(input logic [31:0] imm, input logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'h6f};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pcs  [4];
    logic [31:0] imms [10];
    logic [4:0]  rds  [3];
    pcs  = '{32'h0000_1000, 32'h0000_1002, 32'hFFFF_FFFC, 32'h8000_0000};
    imms = '{32'd0, 32'd2, 32'd4, -32'sd2, -32'sd4, 32'd6, -32'sd8, 32'd12,
             32'h000F_FFFE, 32'hFFF0_0000};
    rds  = '{5'd0, 5'd1, 5'd31};
    last_fault = 32'd0;
    rst = 1'b1; in_valid = 1'b0; in_insn = '0; in_pc = '0; in_cext_en = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(in_ready == 1'b0, "R10 in_ready", 32'(in_ready), 32'd0);
    chk(out_valid == 1'b0 && exc_valid == 1'b0 && out_jump == 1'b0 && out_link_we == 1'b0,
        "R10 strobes", {out_valid, exc_valid, out_jump, out_link_we}, 32'd0);
    chk(out_seq_pc == 0 && fault_pc == 0 && out_target == 0 && out_link_val == 0,
        "R10 values", out_seq_pc | fault_pc | out_target | out_link_val, 32'd0);
    chk(exc_cause == 0 && out_link_rd == 0 && out_short == 0,
        "R10 fields", {exc_cause, out_link_rd, out_short}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 ready after reset", 32'(in_ready), 32'd1);

    for (int c = 0; c < 2; c++) begin
      for (int p = 0; p < 4; p++) begin
        // R1 R3: the three short encodings
        for (int lb = 0; lb < 3; lb++)
          run_one({16'hA5C3, 14'h1234, 2'(lb)}, pcs[p], c[0], 32'd0);
        // R4: non-JAL 32-bit word (register-immediate add opcode)
        run_one(32'h0050_0093, pcs[p], c[0], 32'd0);
        // R4 R5 R6 R7: JAL sweep
        for (int i = 0; i < 10; i++)
          for (int r = 0; r < 3; r++)
            run_one(enc_jal(imms[i], rds[r]), pcs[p], c[0], imms[i]);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule